// File: doc/BRIEF.md
# Dual-Class Threshold Alert Checker

This block watches a stream of decoded conversion samples and raises an alert when a sample lies outside a programmable window. Each sample carries a 4-bit channel code and a 12-bit result. Codes 0 to 5 are cell-voltage channels. Codes 6 to 11 are auxiliary (temperature) channels. Each of the two classes has its own 8-bit upper and lower limit. A limit is widened to 12 bits with zeros above it and then compared with the raw 12-bit result.

For every accepted sample the block produces at most one alert. The alert is a single-cycle strobe carrying a class bit and a direction bit. Crossing the upper limit wins over crossing the lower limit. A small register port writes and reads back the four limits. In engineering units one cell-limit step is 15.68 mV above a 1000 mV floor, and one auxiliary step is 19.6 mV from zero. That conversion is left to software. Channel codes 12 to 15 carry no measurement and are dropped.

Top module: `thresh_alert_top`

## Requirements
- R1: While reset is active, and after it, until a write, both upper limits read 0xFF, both lower limits read 0x00, and `evt_valid` is 0.
- R2: A sample with code 0..5 is judged against the cell limits and its alert has `evt_class`=0. A sample with code 6..11 uses the auxiliary limits and has `evt_class`=1.
- R3: A sample whose 12-bit value is greater than or equal to the zero-extended upper limit of its class gives an alert with `evt_dir`=1 (rising).
- R4: A sample that does not meet R3 and whose value is less than or equal to the zero-extended lower limit gives an alert with `evt_dir`=0 (falling). When both conditions hold, only the rising alert is given.
- R5: A sample strictly between the two limits, or a cycle with `smp_valid`=0, gives no alert.
- R6: The alert for a sample accepted at clock edge k is presented on the outputs from edge k until edge k+1 only: it is a one-cycle pulse, with exactly one register of latency.
- R7: A sample with a channel code of 12 to 15 gives no alert, whatever its value.
- R8: A limit write accepted at an edge applies to samples from the next cycle on. A sample presented in the same cycle as the write is judged against the old limit.
- R9: `cfg_rdata` shows the limit chosen by `cfg_sel`: 0 is the cell upper limit, 1 the cell lower limit, 2 the auxiliary upper limit, and 3 the auxiliary lower limit. A write with `cfg_we`=1 stores `cfg_wdata` into the limit chosen by `cfg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 4 | Channel code of the sample |
| smp_value | input | 12 | Conversion result |
| cfg_we | input | 1 | Write strobe for the limit port |
| cfg_sel | input | 2 | Limit select for write and read-back |
| cfg_wdata | input | 8 | Limit write data |
| cfg_rdata | output | 8 | Selected limit read-back |
| evt_valid | output | 1 | Alert strobe, one cycle |
| evt_class | output | 1 | 0 = cell class, 1 = auxiliary class |
| evt_dir | output | 1 | 1 = rising (upper limit), 0 = falling (lower limit) |

## Verification
Two functions can fall in the same clock cycle: a limit write and a sample that the limit being written governs. The write must not affect that sample, but it must govern the one that follows. Directed steps provoke this case. They write a new cell upper limit together with a sample whose verdict flips under the new value, then repeat the sample. The random phase lets writes and samples coincide freely. The bench model judges each sample against the limits held before any write in that cycle and applies the write only afterwards, so any early or late take-up shows as a mismatch in class, direction or strobe.

// File: rtl/thresh_alert_pkg.sv
package thresh_alert_pkg;
  localparam int NUM_CLASS = 2;
  localparam int SEL_W     = $clog2(2 * NUM_CLASS);

  typedef enum logic {CLS_CELL = 1'b0, CLS_AUX = 1'b1} cls_e;
  typedef enum logic {DIR_FALL = 1'b0, DIR_RISE = 1'b1} dir_e;

  typedef struct packed {
    logic valid;
    cls_e cls;
    dir_e dir;
  } evt_t;
endpackage

// File: rtl/ta_reset_sync.sv
module ta_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ta_limit_bank.sv
module ta_limit_bank
  import thresh_alert_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [LIM_W-1:0]                wr_data,
  output logic [NUM_CLASS-1:0][LIM_W-1:0] hi_lim,
  output logic [NUM_CLASS-1:0][LIM_W-1:0] lo_lim,
  output logic [LIM_W-1:0]                rd_data
);
  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    localparam logic [SEL_W-1:0] HI_CODE = SEL_W'(2 * c);
    localparam logic [SEL_W-1:0] LO_CODE = SEL_W'(2 * c + 1);
    logic             hi_en, lo_en;
    logic [LIM_W-1:0] hi_q, lo_q;

    always_comb begin
      hi_en = wr_en && (wr_sel == HI_CODE);
      lo_en = wr_en && (wr_sel == LO_CODE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '1;
        lo_q <= '0;
      end else begin
        if (hi_en) hi_q <= wr_data;
        if (lo_en) lo_q <= wr_data;
      end
    end

    assign hi_lim[c] = hi_q;
    assign lo_lim[c] = lo_q;
  end

  always_comb begin
    if (wr_sel[0]) rd_data = lo_lim[wr_sel[SEL_W-1:1]];
    else           rd_data = hi_lim[wr_sel[SEL_W-1:1]];
  end
endmodule

// File: rtl/ta_class_cmp.sv
module ta_class_cmp
  import thresh_alert_pkg::*;
#(
  parameter int VAL_W = 12,
  parameter int LIM_W = 8
) (
  input  logic [VAL_W-1:0]                value,
  input  logic [NUM_CLASS-1:0][LIM_W-1:0] hi_lim,
  input  logic [NUM_CLASS-1:0][LIM_W-1:0] lo_lim,
  output logic [NUM_CLASS-1:0]            over,
  output logic [NUM_CLASS-1:0]            under
);
  localparam int PAD_W = VAL_W - LIM_W;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cmp
    logic [VAL_W-1:0] hi_w, lo_w;
    always_comb begin
      hi_w     = {{PAD_W{1'b0}}, hi_lim[c]};
      lo_w     = {{PAD_W{1'b0}}, lo_lim[c]};
      over[c]  = (value >= hi_w);
      under[c] = (value <= lo_w);
    end
  end
endmodule

// File: rtl/ta_event_gen.sv
module ta_event_gen
  import thresh_alert_pkg::*;
#(
  parameter int CHAN_W    = 4,
  parameter int CELL_LAST = 5,
  parameter int AUX_LAST  = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [CHAN_W-1:0]    smp_chan,
  input  logic [NUM_CLASS-1:0] over,
  input  logic [NUM_CLASS-1:0] under,
  output evt_t                 evt_q
);
  localparam logic [CHAN_W-1:0] CELL_MAX = CHAN_W'(CELL_LAST);
  localparam logic [CHAN_W-1:0] AUX_MAX  = CHAN_W'(AUX_LAST);

  logic in_range;
  cls_e cls;
  evt_t evt_d;
  logic load_en;

  always_comb begin
    in_range = (smp_chan <= AUX_MAX);
    cls      = (smp_chan > CELL_MAX) ? CLS_AUX : CLS_CELL;
    evt_d.cls   = cls;
    evt_d.dir   = over[cls] ? DIR_RISE : DIR_FALL;
    evt_d.valid = smp_valid && in_range && (over[cls] || under[cls]);
    load_en     = evt_d.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q.valid <= 1'b0;
      evt_q.cls   <= CLS_CELL;
      evt_q.dir   <= DIR_FALL;
    end else begin
      evt_q.valid <= evt_d.valid;
      if (load_en) begin
        evt_q.cls <= evt_d.cls;
        evt_q.dir <= evt_d.dir;
      end
    end
  end
endmodule

// File: rtl/thresh_alert_top.sv
module thresh_alert_top
  import thresh_alert_pkg::*;
#(
  parameter int CHAN_W    = 4,
  parameter int VAL_W     = 12,
  parameter int LIM_W     = 8,
  parameter int CELL_LAST = 5,
  parameter int AUX_LAST  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [CHAN_W-1:0] smp_chan,
  input  logic [VAL_W-1:0]  smp_value,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [LIM_W-1:0]  cfg_wdata,
  output logic [LIM_W-1:0]  cfg_rdata,
  output logic              evt_valid,
  output logic              evt_class,
  output logic              evt_dir
);
  logic                            rst_sync_n;
  logic [NUM_CLASS-1:0][LIM_W-1:0] hi_lim;
  logic [NUM_CLASS-1:0][LIM_W-1:0] lo_lim;
  logic [NUM_CLASS-1:0]            over;
  logic [NUM_CLASS-1:0]            under;
  evt_t                            evt_q;

  ta_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ta_limit_bank #(.LIM_W(LIM_W)) u_lim (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .hi_lim  (hi_lim),
    .lo_lim  (lo_lim),
    .rd_data (cfg_rdata)
  );

  ta_class_cmp #(.VAL_W(VAL_W), .LIM_W(LIM_W)) u_cmp (
    .value  (smp_value),
    .hi_lim (hi_lim),
    .lo_lim (lo_lim),
    .over   (over),
    .under  (under)
  );

  ta_event_gen #(
    .CHAN_W    (CHAN_W),
    .CELL_LAST (CELL_LAST),
    .AUX_LAST  (AUX_LAST)
  ) u_evt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .smp_valid (smp_valid),
    .smp_chan  (smp_chan),
    .over      (over),
    .under     (under),
    .evt_q     (evt_q)
  );

  assign evt_valid = evt_q.valid;
  assign evt_class = evt_q.cls;
  assign evt_dir   = evt_q.dir;
endmodule

// File: rtl/thresh_alert_chk.sv
module thresh_alert_chk
  import thresh_alert_pkg::*;
#(
  parameter int CHAN_W    = 4,
  parameter int VAL_W     = 12,
  parameter int LIM_W     = 8,
  parameter int CELL_LAST = 5,
  parameter int AUX_LAST  = 11
) (
  input logic                            clk,
  input logic                            rst_sync_n,
  input logic                            smp_valid,
  input logic [CHAN_W-1:0]               smp_chan,
  input logic [VAL_W-1:0]                smp_value,
  input logic                            cfg_we,
  input logic [SEL_W-1:0]                cfg_sel,
  input logic [LIM_W-1:0]                cfg_wdata,
  input logic [LIM_W-1:0]                cfg_rdata,
  input logic [NUM_CLASS-1:0][LIM_W-1:0] hi_lim,
  input logic [NUM_CLASS-1:0][LIM_W-1:0] lo_lim,
  input logic                            evt_valid,
  input logic                            evt_class,
  input logic                            evt_dir
);
  localparam int PAD_W = VAL_W - LIM_W;
  localparam logic [CHAN_W-1:0] CELL_MAX = CHAN_W'(CELL_LAST);
  localparam logic [CHAN_W-1:0] AUX_MAX  = CHAN_W'(AUX_LAST);

  logic             live, is_aux;
  logic [VAL_W-1:0] hi_w, lo_w;

  always_comb begin
    live   = smp_valid && (smp_chan <= AUX_MAX);
    is_aux = (smp_chan > CELL_MAX);
    hi_w   = {{PAD_W{1'b0}}, (is_aux ? hi_lim[1] : hi_lim[0])};
    lo_w   = {{PAD_W{1'b0}}, (is_aux ? lo_lim[1] : lo_lim[0])};
  end

  assert_class_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    live |=> (!evt_valid || (evt_class == $past(is_aux))));

  assert_rise_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && (smp_value >= hi_w)) |=> (evt_valid && evt_dir));

  assert_fall_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && (smp_value < hi_w) && (smp_value <= lo_w)) |=> (evt_valid && !evt_dir));

  assert_quiet_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live && (smp_value < hi_w) && (smp_value > lo_w)) |=> !evt_valid);

  assert_origin_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    evt_valid |-> $past(smp_valid));

  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && (smp_chan > AUX_MAX)) |=> !evt_valid);

  assert_write_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_we |=> (!$stable(cfg_sel) || (cfg_rdata == $past(cfg_wdata))));
endmodule

bind thresh_alert_top thresh_alert_chk #(
  .CHAN_W(CHAN_W), .VAL_W(VAL_W), .LIM_W(LIM_W),
  .CELL_LAST(CELL_LAST), .AUX_LAST(AUX_LAST)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .smp_valid  (smp_valid),
  .smp_chan   (smp_chan),
  .smp_value  (smp_value),
  .cfg_we     (cfg_we),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .hi_lim     (hi_lim),
  .lo_lim     (lo_lim),
  .evt_valid  (evt_valid),
  .evt_class  (evt_class),
  .evt_dir    (evt_dir)
);

// File: tb/sim_thresh_alert_top.sv
`timescale 1ns/1ps
module sim_thresh_alert_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_valid;
  logic [3:0]  smp_chan;
  logic [11:0] smp_value;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        evt_valid, evt_class, evt_dir;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_lim [4];

  always #2 clk = ~clk;

  thresh_alert_top u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_value(smp_value), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .evt_valid(evt_valid),
    .evt_class(evt_class), .evt_dir(evt_dir)
  );

  function automatic logic [2:0] model_evt(logic v, logic [3:0] ch, logic [11:0] val);
    logic       c;
    logic [7:0] hi, lo;
    c  = (ch > 4'd5);
    hi = m_lim[{c, 1'b0}];
    lo = m_lim[{c, 1'b1}];
    if (!v || ch > 4'd11)       return 3'b000;
    if (val >= {4'h0, hi})      return {1'b1, c, 1'b1};
    if (val <= {4'h0, lo})      return {1'b1, c, 1'b0};
    return 3'b000;
  endfunction

  function automatic string tag_of(logic v, logic [3:0] ch, logic [2:0] e);
    if (!v)         return "R5";
    if (ch > 4'd11) return "R7";
    if (e[2] && e[0]) return "R3";
    if (e[2])       return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, judge at the next falling edge.
  task automatic step(logic v, logic [3:0] ch, logic [11:0] val,
                      logic we, logic [1:0] sel, logic [7:0] wd, string force_tag = "");
    logic [2:0] e;
    string t;
    smp_valid = v; smp_chan = ch; smp_value = val;
    cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
    @(negedge clk);
    e = model_evt(v, ch, val);
    t = (force_tag != "") ? force_tag : tag_of(v, ch, e);
    check(t, {7'd0, evt_valid}, {7'd0, e[2]});
    if (e[2]) begin
      check("R2", {7'd0, evt_class}, {7'd0, e[1]});
      check(t, {7'd0, evt_dir}, {7'd0, e[0]});
    end
    if (we) m_lim[sel] = wd;
    check("R9", cfg_rdata, m_lim[sel]);
    smp_valid = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_value = '0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    m_lim[0] = 8'hFF; m_lim[1] = 8'h00; m_lim[2] = 8'hFF; m_lim[3] = 8'h00;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: reset values and quiet output while reset is held
    for (int s = 0; s < 4; s++) begin
      cfg_sel = 2'(s);
      #1 check("R1", cfg_rdata, m_lim[s]);
    end
    check("R1", {7'd0, evt_valid}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", {7'd0, evt_valid}, 8'd0);

    // reset limits: 255 rises, 254 quiet, 0 falls
    step(1, 4'd0, 12'd255, 0, 2'd0, 8'h00);
    step(1, 4'd3, 12'd254, 0, 2'd1, 8'h00);
    step(1, 4'd5, 12'd0,   0, 2'd2, 8'h00);
    step(1, 4'd11, 12'd0,  0, 2'd3, 8'h00);
    step(0, 4'd0, 12'd4095, 0, 2'd0, 8'h00, "R6");
    // R7: codes above 11 never alert
    step(1, 4'd12, 12'd4095, 0, 2'd0, 8'h00, "R7");
    step(1, 4'd15, 12'd0,    0, 2'd0, 8'h00, "R7");
    // R8: write collides with a sample, old limit applies, then new
    step(1, 4'd2, 12'h090, 1, 2'd0, 8'h80, "R8");
    step(1, 4'd2, 12'h090, 0, 2'd0, 8'h00, "R8");
    // R6: pulse lasts one cycle
    step(0, 4'd2, 12'h090, 0, 2'd0, 8'h00, "R6");
    // cell window 0x20..0x80 boundaries
    step(1, 4'd1, 12'h000, 1, 2'd1, 8'h20);
    step(1, 4'd1, 12'h020, 0, 2'd1, 8'h00, "R4");
    step(1, 4'd1, 12'h021, 0, 2'd1, 8'h00, "R5");
    step(1, 4'd4, 12'h07F, 0, 2'd0, 8'h00, "R5");
    step(1, 4'd4, 12'h080, 0, 2'd0, 8'h00, "R3");
    step(1, 4'd4, 12'h100, 0, 2'd0, 8'h00, "R3");
    // R4: overlapping auxiliary window, rising wins
    step(0, 4'd0, 12'h000, 1, 2'd2, 8'h10);
    step(0, 4'd0, 12'h000, 1, 2'd3, 8'h40);
    step(1, 4'd7, 12'h020, 0, 2'd2, 8'h00, "R4");
    step(1, 4'd6, 12'h010, 0, 2'd3, 8'h00, "R3");
    step(1, 4'd6, 12'h00F, 0, 2'd3, 8'h00, "R4");
    // R2: same value, different class
    step(1, 4'd5, 12'h030, 0, 2'd0, 8'h00, "R2");
    step(1, 4'd6, 12'h030, 0, 2'd0, 8'h00, "R2");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  ch;
      logic [11:0] val;
      logic [7:0]  base;
      ch   = 4'($urandom_range(0, 15));
      base = m_lim[{(ch > 4'd5), 1'($urandom_range(0, 1))}];
      case ($urandom_range(0, 3))
        0: val = 12'($urandom_range(0, 4095));
        1: val = 12'($urandom_range(0, 300));
        default: val = 12'({4'h0, base}) + 12'($urandom_range(0, 2)) - 12'd1;
      endcase
      step(1'($urandom_range(0, 4) != 0), ch, val,
           1'($urandom_range(0, 6) == 0), 2'($urandom_range(0, 3)),
           8'($urandom_range(0, 255)));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule